// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer with Low-Power State Codes

This block is the main sequencer for a multicycle load/store datapath. It takes the 6-bit opcode held in the instruction register. Each clock it moves through the steps of one instruction: fetch, decode, address calculation, memory access, execution, writeback, branch, jump or trap. It drives the datapath strobes that each step needs. The machine is Moore-style: every strobe comes only from the state register, so the strobes are stable for the whole cycle and do not depend on the opcode.

The state register holds one of three codes, chosen at build time by the `ENC` parameter. The first code is a 4-bit assignment in which the frequent transitions flip a single bit. The second is the same kind of assignment with two equivalent Fetch states. Each path that ends an instruction returns to the copy that lies closer in Hamming distance. The third is one flip-flop per state. In all three, the same opcode stream gives the same strobes in every cycle, so the choice trades flip-flop count against switching activity without changing the function. The state register is brought out so that its activity can be measured.

Top module: `mc_ctrl`

## Requirements
- R1: A synchronous reset puts the machine in Fetch. The state code is 0000 in both 4-bit modes (the first Fetch copy when duplication is on) and bit 0 in one-hot mode.
- R2: The strobes, packed as {pc_wr, mem_addr_sel, mem_wr, ir_wr, reg_wr, reg_dst, wb_sel_mem, alu_src_a, alu_src_b[1:0], alu_op[1:0], pc_src[1:0], br_en}, depend only on the state. Fetch sets pc_wr, ir_wr and alu_src_b=01. Decode sets alu_src_b=11. Address sets alu_src_a and alu_src_b=10. Read sets mem_addr_sel. Load writeback sets reg_wr and wb_sel_mem. Store sets mem_addr_sel and mem_wr. Execute sets alu_src_a and alu_op=10. ALU writeback sets reg_wr and reg_dst. Branch sets alu_src_a, alu_op=01, pc_src=01 and br_en. Jump sets pc_wr with pc_src=10. Trap sets pc_wr with pc_src=11. Every other strobe is 0.
- R3: In Decode the opcode selects the next state. 000000 goes to Execute, 100011 and 101011 go to Address, 000100 goes to Branch, 000010 goes to Jump, and every other value goes to Trap. In Address, opcode 100011 goes to Read and anything else goes to Store.
- R4: The paths are: Fetch→Decode always; Address→Read→Load writeback→Fetch; Address→Store→Fetch; Execute→ALU writeback→Fetch; Branch→Fetch; Jump→Fetch; Trap→Fetch.
- R5: In the 4-bit low-power mode the codes are Fetch 0000, Decode 0001, Address 0011, Read 0111, Load writeback 0110, Store 0010, Execute 0101, ALU writeback 0100, Branch 1001, Jump 1000 and Trap 1011. No transition flips more than three bits.
- R6: In duplicated-Fetch mode the codes are Fetch1 0000, Fetch2 1001 and Branch 1101, and every other code is as in R5. A return to Fetch goes to the copy at the smaller Hamming distance from the current code, with a tie going to Fetch1. No transition flips more than three bits.
- R7: In one-hot mode state k, in the order Fetch, Decode, Address, Read, Load writeback, Store, Execute, ALU writeback, Branch, Jump, Trap, sets bit k alone. Every state change flips exactly two bits.
- R8: For the same opcode stream, all three modes drive identical strobes in every cycle.
- R9: Over a sweep of all 64 opcodes, the low-power mode flips fewer state bits in total than a plain assignment that numbers the states 0 to 10 in the R7 order. The duplicated-Fetch mode flips fewer still.
- R10: Reset takes priority over the next-state choice. A reset applied in Branch or Trap, whose natural return is Fetch2, still lands in Fetch1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the held instruction |
| pc_wr | output | 1 | Program counter write |
| mem_addr_sel | output | 1 | Memory address from ALU result (1) or program counter (0) |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register write |
| reg_wr | output | 1 | Register file write |
| reg_dst | output | 1 | Destination register field select |
| wb_sel_mem | output | 1 | Writeback data from memory (1) or ALU (0) |
| alu_src_a | output | 1 | ALU A operand select |
| alu_src_b | output | 2 | ALU B operand select |
| alu_op | output | 2 | ALU operation class |
| pc_src | output | 2 | Next program counter source |
| br_en | output | 1 | Conditional branch enable |
| state_q | output | 4 or 11 | State register (11 bits in one-hot mode) |

## Verification
The clash that matters is a reset arriving in the same cycle that the duplicated-Fetch logic chooses which Fetch copy to return to. The bench provokes it by asserting reset while the machine sits in Branch and then again in Trap, the two states whose natural return is Fetch2. It judges the result by requiring code 0000 in every 4-bit mode and bit 0 in one-hot mode on the next cycle, with Fetch strobes on all three instances.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;

    localparam int ENC_LP  = 0;
    localparam int ENC_DUP = 1;
    localparam int ENC_OH  = 2;

    localparam int NUM_ST = 11;
    localparam int BIN_W  = 4;

    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_LOAD  = 6'b100011;
    localparam logic [5:0] OP_STORE = 6'b101011;
    localparam logic [5:0] OP_BEQ   = 6'b000100;
    localparam logic [5:0] OP_JUMP  = 6'b000010;

    typedef enum logic [3:0] {
        S_FETCH, S_DECODE, S_MADR, S_MRD, S_MWB, S_MWR,
        S_EXE, S_AWB, S_BR, S_JMP, S_TRAP
    } state_e;

    typedef struct packed {
        logic       pc_wr;
        logic       mem_addr_sel;
        logic       mem_wr;
        logic       ir_wr;
        logic       reg_wr;
        logic       reg_dst;
        logic       wb_sel_mem;
        logic       alu_src_a;
        logic [1:0] alu_src_b;
        logic [1:0] alu_op;
        logic [1:0] pc_src;
        logic       br_en;
    } ctrl_t;

    // explicit binary state codes
    localparam logic [3:0] C_FETCH  = 4'b0000;
    localparam logic [3:0] C_FETCH2 = 4'b1001;
    localparam logic [3:0] C_DECODE = 4'b0001;
    localparam logic [3:0] C_MADR   = 4'b0011;
    localparam logic [3:0] C_MRD    = 4'b0111;
    localparam logic [3:0] C_MWB    = 4'b0110;
    localparam logic [3:0] C_MWR    = 4'b0010;
    localparam logic [3:0] C_EXE    = 4'b0101;
    localparam logic [3:0] C_AWB    = 4'b0100;
    localparam logic [3:0] C_BR_LP  = 4'b1001;
    localparam logic [3:0] C_BR_DUP = 4'b1101;
    localparam logic [3:0] C_JMP    = 4'b1000;
    localparam logic [3:0] C_TRAP   = 4'b1011;

    function automatic int state_w(int enc);
        return (enc == ENC_OH) ? NUM_ST : BIN_W;
    endfunction

    function automatic logic [3:0] bin_code(state_e s, bit dup);
        logic [3:0] c;
        case (s)
            S_FETCH:  c = C_FETCH;
            S_DECODE: c = C_DECODE;
            S_MADR:   c = C_MADR;
            S_MRD:    c = C_MRD;
            S_MWB:    c = C_MWB;
            S_MWR:    c = C_MWR;
            S_EXE:    c = C_EXE;
            S_AWB:    c = C_AWB;
            S_BR:     c = dup ? C_BR_DUP : C_BR_LP;
            S_JMP:    c = C_JMP;
            default:  c = C_TRAP;
        endcase
        return c;
    endfunction

    function automatic int unsigned hdist(logic [3:0] a, logic [3:0] b);
        return $countones(a ^ b);
    endfunction

    function automatic ctrl_t ctrl_of(state_e s);
        ctrl_t c;
        c = '0;
        case (s)
            S_FETCH: begin
                c.pc_wr = 1'b1; c.ir_wr = 1'b1; c.alu_src_b = 2'b01;
            end
            S_DECODE: c.alu_src_b = 2'b11;
            S_MADR: begin
                c.alu_src_a = 1'b1; c.alu_src_b = 2'b10;
            end
            S_MRD:  c.mem_addr_sel = 1'b1;
            S_MWB: begin
                c.reg_wr = 1'b1; c.wb_sel_mem = 1'b1;
            end
            S_MWR: begin
                c.mem_addr_sel = 1'b1; c.mem_wr = 1'b1;
            end
            S_EXE: begin
                c.alu_src_a = 1'b1; c.alu_op = 2'b10;
            end
            S_AWB: begin
                c.reg_wr = 1'b1; c.reg_dst = 1'b1;
            end
            S_BR: begin
                c.alu_src_a = 1'b1; c.alu_op = 2'b01;
                c.pc_src = 2'b01; c.br_en = 1'b1;
            end
            S_JMP: begin
                c.pc_wr = 1'b1; c.pc_src = 2'b10;
            end
            S_TRAP: begin
                c.pc_wr = 1'b1; c.pc_src = 2'b11;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

    function automatic state_e next_of(state_e s, logic [5:0] op);
        state_e n;
        case (s)
            S_FETCH: n = S_DECODE;
            S_DECODE: begin
                case (op)
                    OP_RTYPE:          n = S_EXE;
                    OP_LOAD, OP_STORE: n = S_MADR;
                    OP_BEQ:            n = S_BR;
                    OP_JUMP:           n = S_JMP;
                    default:           n = S_TRAP;
                endcase
            end
            S_MADR:  n = (op == OP_LOAD) ? S_MRD : S_MWR;
            S_MRD:   n = S_MWB;
            S_EXE:   n = S_AWB;
            default: n = S_FETCH;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/mc_state_dec.sv
module mc_state_dec
    import ctrl_pkg::*;
#(
    parameter int ENC = ENC_LP,
    parameter int SW  = state_w(ENC)
) (
    input  logic [SW-1:0] code_q,
    output state_e        cur,
    output logic          legal
);

    generate
        if (ENC == ENC_OH) begin : g_oh
            always_comb begin
                cur   = S_FETCH;
                legal = ($countones(code_q) == 1);
                for (int i = 0; i < NUM_ST; i++) begin
                    if (code_q[i]) cur = state_e'(i);
                end
            end
        end else begin : g_bin
            localparam bit DUP = (ENC == ENC_DUP);
            always_comb begin
                cur   = S_FETCH;
                legal = 1'b0;
                for (int i = 0; i < NUM_ST; i++) begin
                    if (code_q[3:0] == bin_code(state_e'(i), DUP)) begin
                        cur   = state_e'(i);
                        legal = 1'b1;
                    end
                end
                if (DUP && code_q[3:0] == C_FETCH2) begin
                    cur   = S_FETCH;
                    legal = 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/mc_state_enc.sv
module mc_state_enc
    import ctrl_pkg::*;
#(
    parameter int ENC = ENC_LP,
    parameter int SW  = state_w(ENC)
) (
    input  state_e        nxt,
    input  logic [SW-1:0] code_q,
    output logic [SW-1:0] code_d
);

    generate
        if (ENC == ENC_OH) begin : g_oh
            logic unused_code;
            assign unused_code = ^code_q;
            assign code_d = {{(SW-1){1'b0}}, 1'b1} << nxt;
        end else if (ENC == ENC_DUP) begin : g_dup
            logic pick_f2;
            assign pick_f2 = hdist(code_q[3:0], C_FETCH2) < hdist(code_q[3:0], C_FETCH);
            always_comb begin
                if (nxt == S_FETCH) code_d = SW'(pick_f2 ? C_FETCH2 : C_FETCH);
                else                code_d = SW'(bin_code(nxt, 1'b1));
            end
        end else begin : g_lp
            logic unused_code;
            assign unused_code = ^code_q;
            assign code_d = SW'(bin_code(nxt, 1'b0));
        end
    endgenerate

endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
    import ctrl_pkg::*;
(
    input  state_e     cur,
    input  logic       legal,
    input  logic [5:0] opcode,
    output state_e     nxt
);

    always_comb begin
        if (legal) nxt = next_of(cur, opcode);
        else       nxt = S_FETCH;
    end

endmodule

// File: rtl/mc_out_dec.sv
module mc_out_dec
    import ctrl_pkg::*;
(
    input  state_e cur,
    input  logic   legal,
    output ctrl_t  ctrl
);

    always_comb begin
        if (legal) ctrl = ctrl_of(cur);
        else       ctrl = '0;
    end

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import ctrl_pkg::*;
#(
    parameter int ENC = ENC_LP
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [5:0]                    opcode,
    output logic                          pc_wr,
    output logic                          mem_addr_sel,
    output logic                          mem_wr,
    output logic                          ir_wr,
    output logic                          reg_wr,
    output logic                          reg_dst,
    output logic                          wb_sel_mem,
    output logic                          alu_src_a,
    output logic [1:0]                    alu_src_b,
    output logic [1:0]                    alu_op,
    output logic [1:0]                    pc_src,
    output logic                          br_en,
    output logic [ctrl_pkg::state_w(ENC)-1:0] state_q
);

    localparam int SW = state_w(ENC);
    localparam logic [SW-1:0] RST_CODE = SW'((ENC == ENC_OH) ? 1 : 0);

    logic [SW-1:0] code_q;
    logic [SW-1:0] code_d;
    state_e        cur;
    state_e        nxt;
    logic          legal;
    ctrl_t         ctrl;

    always_ff @(posedge clk) begin
        if (rst) code_q <= RST_CODE;
        else     code_q <= code_d;
    end

    mc_state_dec #(.ENC(ENC), .SW(SW)) u_dec (
        .code_q (code_q),
        .cur    (cur),
        .legal  (legal)
    );

    mc_next_state u_nxt (
        .cur    (cur),
        .legal  (legal),
        .opcode (opcode),
        .nxt    (nxt)
    );

    mc_state_enc #(.ENC(ENC), .SW(SW)) u_enc (
        .nxt    (nxt),
        .code_q (code_q),
        .code_d (code_d)
    );

    mc_out_dec u_out (
        .cur    (cur),
        .legal  (legal),
        .ctrl   (ctrl)
    );

    assign pc_wr        = ctrl.pc_wr;
    assign mem_addr_sel = ctrl.mem_addr_sel;
    assign mem_wr       = ctrl.mem_wr;
    assign ir_wr        = ctrl.ir_wr;
    assign reg_wr       = ctrl.reg_wr;
    assign reg_dst      = ctrl.reg_dst;
    assign wb_sel_mem   = ctrl.wb_sel_mem;
    assign alu_src_a    = ctrl.alu_src_a;
    assign alu_src_b    = ctrl.alu_src_b;
    assign alu_op       = ctrl.alu_op;
    assign pc_src       = ctrl.pc_src;
    assign br_en        = ctrl.br_en;
    assign state_q      = code_q;

endmodule

// File: rtl/mc_ctrl_chk.sv
module mc_ctrl_chk
    import ctrl_pkg::*;
#(
    parameter int ENC = ENC_LP,
    parameter int SW  = state_w(ENC)
) (
    input logic          clk,
    input logic          rst,
    input logic [SW-1:0] state_q,
    input logic          pc_wr,
    input logic          ir_wr,
    input logic          reg_wr,
    input logic          mem_wr,
    input logic          br_en,
    input logic [1:0]    alu_src_b
);

    localparam logic [SW-1:0] RST_CODE = SW'((ENC == ENC_OH) ? 1 : 0);

    logic seen  = 1'b0;
    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        seen  <= seen | rst;
        armed <= seen & ~rst;
    end

    AST_RESET_FETCH: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> state_q == RST_CODE);                         // R1

    AST_FETCH_DECODE: assert property (@(posedge clk) disable iff (rst)
        ir_wr |=> (alu_src_b == 2'b11 && !pc_wr));                   // R4

    AST_WB_RETURN: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> ir_wr);                                           // R4

    AST_STORE_RETURN: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> ir_wr);                                           // R4

    AST_BRANCH_RETURN: assert property (@(posedge clk) disable iff (rst)
        br_en |=> ir_wr);                                            // R4

    generate
        if (ENC == ENC_OH) begin : g_oh
            AST_ONEHOT_SINGLE: assert property (@(posedge clk) disable iff (rst)
                armed |-> $countones(state_q) == 1);                 // R7

            AST_ONEHOT_TWO_FLIPS: assert property (@(posedge clk) disable iff (rst)
                (armed && state_q != $past(state_q))
                |-> $countones(state_q ^ $past(state_q)) == 2);      // R7
        end else begin : g_bin
            AST_MAX_FLIPS: assert property (@(posedge clk) disable iff (rst)
                armed |-> $countones(state_q ^ $past(state_q)) <= 3); // R5
        end
    endgenerate

endmodule

bind mc_ctrl mc_ctrl_chk #(.ENC(ENC), .SW(SW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .state_q   (code_q),
    .pc_wr     (pc_wr),
    .ir_wr     (ir_wr),
    .reg_wr    (reg_wr),
    .mem_wr    (mem_wr),
    .br_en     (br_en),
    .alu_src_b (alu_src_b)
);

// File: tb/tb_mc_ctrl.sv
module tb_mc_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;

    always #2 clk = ~clk;

    wire [14:0] c0, c1, c2;
    wire [3:0]  q_lp, q_dup;
    wire [10:0] q_oh;

    mc_ctrl #(.ENC(0)) dut (
        .clk(clk), .rst(rst), .opcode(opcode),
        .pc_wr(c0[14]), .mem_addr_sel(c0[13]), .mem_wr(c0[12]), .ir_wr(c0[11]),
        .reg_wr(c0[10]), .reg_dst(c0[9]), .wb_sel_mem(c0[8]), .alu_src_a(c0[7]),
        .alu_src_b(c0[6:5]), .alu_op(c0[4:3]), .pc_src(c0[2:1]), .br_en(c0[0]),
        .state_q(q_lp)
    );

    mc_ctrl #(.ENC(1)) dut_dup (
        .clk(clk), .rst(rst), .opcode(opcode),
        .pc_wr(c1[14]), .mem_addr_sel(c1[13]), .mem_wr(c1[12]), .ir_wr(c1[11]),
        .reg_wr(c1[10]), .reg_dst(c1[9]), .wb_sel_mem(c1[8]), .alu_src_a(c1[7]),
        .alu_src_b(c1[6:5]), .alu_op(c1[4:3]), .pc_src(c1[2:1]), .br_en(c1[0]),
        .state_q(q_dup)
    );

    mc_ctrl #(.ENC(2)) dut_oh (
        .clk(clk), .rst(rst), .opcode(opcode),
        .pc_wr(c2[14]), .mem_addr_sel(c2[13]), .mem_wr(c2[12]), .ir_wr(c2[11]),
        .reg_wr(c2[10]), .reg_dst(c2[9]), .wb_sel_mem(c2[8]), .alu_src_a(c2[7]),
        .alu_src_b(c2[6:5]), .alu_op(c2[4:3]), .pc_src(c2[2:1]), .br_en(c2[0]),
        .state_q(q_oh)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // expected model (state numbers follow the R7 order)
    int es = 0;
    int pes = 0;
    bit ef2 = 0;
    bit have_prev = 0;
    logic [3:0]  plp, pdup;
    logic [10:0] poh;
    int tog_lp = 0, tog_dup = 0, tog_arb = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // R2 strobe table
    function automatic logic [14:0] exp_ctrl(int s);
        case (s)
            0:  return 15'b1_0_0_1_0_0_0_0_01_00_00_0;
            1:  return 15'b0_0_0_0_0_0_0_0_11_00_00_0;
            2:  return 15'b0_0_0_0_0_0_0_1_10_00_00_0;
            3:  return 15'b0_1_0_0_0_0_0_0_00_00_00_0;
            4:  return 15'b0_0_0_0_1_0_1_0_00_00_00_0;
            5:  return 15'b0_1_1_0_0_0_0_0_00_00_00_0;
            6:  return 15'b0_0_0_0_0_0_0_1_00_10_00_0;
            7:  return 15'b0_0_0_0_1_1_0_0_00_00_00_0;
            8:  return 15'b0_0_0_0_0_0_0_1_00_01_01_1;
            9:  return 15'b1_0_0_0_0_0_0_0_00_00_10_0;
            default: return 15'b1_0_0_0_0_0_0_0_00_00_11_0;
        endcase
    endfunction

    // R5 code table
    function automatic logic [3:0] exp_lp(int s);
        case (s)
            0: return 4'b0000; 1: return 4'b0001; 2: return 4'b0011;
            3: return 4'b0111; 4: return 4'b0110; 5: return 4'b0010;
            6: return 4'b0101; 7: return 4'b0100; 8: return 4'b1001;
            9: return 4'b1000; default: return 4'b1011;
        endcase
    endfunction

    // R6 code table
    function automatic logic [3:0] exp_dup(int s, bit f2);
        if (s == 0) return f2 ? 4'b1001 : 4'b0000;
        if (s == 8) return 4'b1101;
        return exp_lp(s);
    endfunction

    // R3 and R4 path rules
    function automatic int exp_next(int s, logic [5:0] op);
        case (s)
            0: return 1;
            1: begin
                if (op == 6'b000000) return 6;
                if (op == 6'b100011 || op == 6'b101011) return 2;
                if (op == 6'b000100) return 8;
                if (op == 6'b000010) return 9;
                return 10;
            end
            2: return (op == 6'b100011) ? 3 : 5;
            3: return 4;
            6: return 7;
            default: return 0;
        endcase
    endfunction

    task automatic observe(input bit was_reset);
        string ptag;
        ptag = was_reset ? "R10" : ((pes == 1) ? "R3" : "R4");
        chk(ptag,  32'(q_oh), 32'(11'd1 << es));
        chk("R2",  32'(c0), 32'(exp_ctrl(es)));
        chk("R8",  32'(c1), 32'(c0));
        chk("R8",  32'(c2), 32'(c0));
        chk(was_reset ? "R10" : "R5", 32'(q_lp), 32'(exp_lp(es)));
        chk(was_reset ? "R10" : "R6", 32'(q_dup), 32'(exp_dup(es, ef2)));
        chk("R7",  32'($countones(q_oh)), 32'd1);
        if (have_prev) begin
            chk("R5", 32'($countones(q_lp ^ plp) <= 3), 32'd1);
            chk("R6", 32'($countones(q_dup ^ pdup) <= 3), 32'd1);
            if (q_oh != poh)
                chk("R7", 32'($countones(q_oh ^ poh)), 32'd2);
            tog_lp  += $countones(q_lp ^ plp);
            tog_dup += $countones(q_dup ^ pdup);
            tog_arb += $countones(4'(es) ^ 4'(pes));
        end
        have_prev = 1;
        plp = q_lp; pdup = q_dup; poh = q_oh;
        pes = es;
    endtask

    // one cycle; the opcode is loaded while the machine is in Fetch
    task automatic advance(input logic [5:0] op);
        int nes;
        if (es == 0) opcode = op;
        nes = exp_next(es, opcode);
        if (nes == 0)
            ef2 = $countones(exp_dup(es, 0) ^ 4'b1001) < $countones(exp_dup(es, 0) ^ 4'b0000);
        else
            ef2 = 0;
        es = nes;
        @(negedge clk);
        observe(0);
    endtask

    task automatic reset_now();
        rst = 1'b1;
        es = 0; ef2 = 0;
        @(negedge clk);
        observe(1);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [5:0] stream [0:83];
        for (int i = 0; i < 64; i++) stream[i] = 6'(i);
        for (int i = 0; i < 4; i++) begin
            stream[64 + 5*i + 0] = 6'b000000;
            stream[64 + 5*i + 1] = 6'b100011;
            stream[64 + 5*i + 2] = 6'b101011;
            stream[64 + 5*i + 3] = 6'b000100;
            stream[64 + 5*i + 4] = 6'b000010;
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", 32'(q_lp), 32'h0);
        chk("R1", 32'(q_dup), 32'h0);
        chk("R1", 32'(q_oh), 32'h1);
        chk("R1", 32'(c0), 32'(exp_ctrl(0)));
        observe(0);
        rst = 1'b0;

        // sweep: every opcode, then the supported classes repeated
        for (int k = 0; k < 84; k++) begin
            advance(stream[k]);
            while (es != 0) advance(stream[k]);
        end

        // R9: switching activity comparison over the sweep
        chk("R9", 32'(tog_lp < tog_arb), 32'd1);
        chk("R9", 32'(tog_dup < tog_lp), 32'd1);

        // R10: reset while in Branch, whose natural return is Fetch2
        advance(6'b000100);
        advance(6'b000100);
        chk("R6", 32'(q_dup), 32'hD);
        reset_now();

        // R10: reset while in Trap
        advance(6'b111111);
        advance(6'b111111);
        chk("R6", 32'(q_dup), 32'hB);
        reset_now();

        // recovery after reset: one jump instruction
        advance(6'b000010);
        while (es != 0) advance(6'b000010);

        finish_run();
    end

endmodule